// File: doc/BRIEF.md
# NAND Flash Host Bridge with Byte ECC

This block sits between a processor's register bus and a raw 8-bit NAND flash device. Software drives the flash control lines (command latch, address latch, two chip enables, write protect) by writing a control register. It moves command, address and data bytes through a single data register. Every byte that crosses the data register, in either direction, is also fed to a Hamming-style ECC engine. The engine keeps 16 line-parity bits, 6 column-parity bits and a byte counter. Software reads these back at the end of a 256-byte block and clears them before the next one.

The host side is a request/response stream. A request (`req_valid`/`req_ready`) carries an offset, a read/write flag, a word-size flag and one write byte. `req_ready` is high only while the bridge is idle with no response pending, so the host is held off until the previous access is complete. Each read produces exactly one response (`rsp_valid`/`rsp_ready`). That response stays valid, with its data frozen, until the host accepts it, and a new request is not taken before then. Writes produce no response.

On the flash side there are separate output-data, input-data, write-strobe and read-strobe lines. The bridge samples the input data in the same cycle as the one-cycle read strobe. The ready/busy input is only reflected in the control readback.

Top module: `nand_ecc_bridge`

## Requirements
- R1: Writing offset 0x18 stores the 8-bit value with bit 5 forced to 0. From the next cycle, fl_ce[0] follows bit 0, fl_cle bit 1, fl_ale bit 2, fl_wp bit 3 and fl_ce[1] bit 4.
- R2: Reading offset 0x18 returns the stored control byte with bit 5 replaced by the current level of fl_ryby.
- R3: Writing offset 0x14 emits exactly one fl_we pulse with fl_dout equal to the written byte, and feeds that byte to the ECC engine.
- R4: A byte read of offset 0x14 emits exactly one fl_re pulse and returns the sampled fl_din in bits 7:0, with all other bits 0; the byte is fed to the ECC engine.
- R5: A word read (req_word=1) of offset 0x14 emits two fl_re pulses. The first byte is returned in bits 7:0 and the second in bits 23:16, with bits 15:8 and 31:24 zero. Both bytes go through the ECC engine.
- R6: Offset 0x0C reads the number of ECC bytes processed since the last clear, modulo 256.
- R7: Let i be the byte's index modulo 256 and p the XOR of its bits. For index bit k, E[k] accumulates p of bytes with bit k of i clear, and O[k] accumulates p of bytes with that bit set. Offset 0x00 returns E[j] at bit 2j and O[j] at bit 2j+1 for j=0..3. Offset 0x04 returns the same pattern for k=j+4.
- R8: Offset 0x08 returns column parity in bits 5:0 and 0 in bits 7:6. Bit 2g accumulates the XOR of data bits whose position has bit g clear, and bit 2g+1 the XOR of data bits whose position has bit g set (g=0..2).
- R9: Any write to offset 0x10 sets the counter and all parity bits to 0 whatever the value written, and emits no flash strobe.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x14, 0x18 returns 0 and raises bad_addr for exactly one cycle. A write to such an offset (or to 0x00-0x0C) changes no state and no pin.
- R11: req_ready is low whenever a response is pending. rsp_valid and rsp_rdata hold unchanged while rsp_ready is low. Each read yields one response; writes yield none.
- R12: After reset, all flash control outputs are low and the counter and all parities read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | Word-size read (two flash bytes at the data port) |
| req_addr | input | ADDR_W | Register offset within the window |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_rdata | output | 32 | Read data |
| bad_addr | output | 1 | One-cycle pulse on a read of an undefined offset |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_din | input | 8 | Byte from the flash, sampled while fl_re is high |
| fl_we | output | 1 | One-cycle write strobe to the flash |
| fl_re | output | 1 | One-cycle read strobe to the flash |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce | output | 2 | Chip enables 1 and 0 |
| fl_wp | output | 1 | Write protect |
| fl_ryby | input | 1 | Ready/busy from the flash |

## Verification
The ECC is driven with a table of distinct bytes: all-zero, all-one, single-bit and mixed patterns. These separate even from odd line-parity slots and each column-parity group. A run of 258 bytes crosses the 256 boundary, so that the counter wrap and the index reuse in the line parity show up. Mixed sequences of data-port writes, byte reads and word reads check that both directions feed the same engine and that word packing places the bytes correctly. A clear written with a non-zero value, a held-off response, and undefined offsets in both directions check that nothing leaks into the parity or pin state.

// File: rtl/nfb_pkg.sv
`timescale 1ns/1ps
package nfb_pkg;
  localparam int OFS_LP_LO = 'h00;
  localparam int OFS_LP_HI = 'h04;
  localparam int OFS_COL   = 'h08;
  localparam int OFS_CNT   = 'h0C;
  localparam int OFS_CLR   = 'h10;
  localparam int OFS_IO    = 'h14;
  localparam int OFS_CTL   = 'h18;

  localparam int CB_CE0  = 0;
  localparam int CB_CLE  = 1;
  localparam int CB_ALE  = 2;
  localparam int CB_WP   = 3;
  localparam int CB_CE1  = 4;
  localparam int CB_BUSY = 5;

  localparam int IDX_W  = 8;   // byte index inside a 256-byte block
  localparam int COL_W  = 6;
  localparam int HALF_W = IDX_W / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_RESP} nfb_state_e;
  typedef enum logic [2:0] {
    SEL_LPLO, SEL_LPHI, SEL_COL, SEL_CNT, SEL_CLR, SEL_IO, SEL_CTL, SEL_BAD
  } nfb_sel_e;

  // mask of the data-bit positions whose position bit g equals v
  function automatic logic [7:0] col_mask(input int g, input logic v);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = (((b >> g) & 1) == int'(v));
    return m;
  endfunction
endpackage

// File: rtl/nfb_ecc.sv
`timescale 1ns/1ps
module nfb_ecc
  import nfb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic [IDX_W-1:0] par_even,
  output logic [IDX_W-1:0] par_odd,
  output logic [COL_W-1:0] col_par,
  output logic [IDX_W-1:0] count
);
  logic byte_par;
  assign byte_par = ^byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clr)      count <= '0;
    else if (byte_vld) count <= count + 1'b1;
  end

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        par_even[k] <= 1'b0;
        par_odd[k]  <= 1'b0;
      end else if (clr) begin
        par_even[k] <= 1'b0;
        par_odd[k]  <= 1'b0;
      end else if (byte_vld) begin
        if (count[k]) par_odd[k]  <= par_odd[k]  ^ byte_par;
        else          par_even[k] <= par_even[k] ^ byte_par;
      end
    end
  end

  for (genvar g = 0; g < COL_W/2; g++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_par[2*g]   <= 1'b0;
        col_par[2*g+1] <= 1'b0;
      end else if (clr) begin
        col_par[2*g]   <= 1'b0;
        col_par[2*g+1] <= 1'b0;
      end else if (byte_vld) begin
        col_par[2*g]   <= col_par[2*g]   ^ (^(byte_in & col_mask(g, 1'b0)));
        col_par[2*g+1] <= col_par[2*g+1] ^ (^(byte_in & col_mask(g, 1'b1)));
      end
    end
  end

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !clr) |=> count == $past(count) + 1'b1);
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && par_even == '0 && par_odd == '0 && col_par == '0));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !clr) |=> $stable(count) && $stable(col_par));
endmodule

// File: rtl/nfb_ctlreg.sv
`timescale 1ns/1ps
module nfb_ctlreg
  import nfb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ryby,
  output logic [7:0] ctl_rd,
  output logic       fl_cle,
  output logic       fl_ale,
  output logic [1:0] fl_ce,
  output logic       fl_wp
);
  logic [7:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data & ~(8'd1 << CB_BUSY);
  end

  always_comb begin
    ctl_rd          = ctl_q;
    ctl_rd[CB_BUSY] = ryby;
  end

  assign fl_cle = ctl_q[CB_CLE];
  assign fl_ale = ctl_q[CB_ALE];
  assign fl_wp  = ctl_q[CB_WP];
  assign fl_ce  = {ctl_q[CB_CE1], ctl_q[CB_CE0]};

  a_r1_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fl_cle == $past(wr_data[CB_CLE]) && fl_ale == $past(wr_data[CB_ALE])
               && fl_wp == $past(wr_data[CB_WP]) && fl_ce[0] == $past(wr_data[CB_CE0])
               && fl_ce[1] == $past(wr_data[CB_CE1])));
  a_r2_busy_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !ryby |-> !ctl_rd[CB_BUSY]);
  a_r1_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fl_ce) && $stable(fl_cle) && $stable(fl_ale) && $stable(fl_wp));
endmodule

// File: rtl/nfb_rdmux.sv
`timescale 1ns/1ps
module nfb_rdmux
  import nfb_pkg::*;
(
  input  nfb_sel_e         sel,
  input  logic [IDX_W-1:0] par_even,
  input  logic [IDX_W-1:0] par_odd,
  input  logic [COL_W-1:0] col_par,
  input  logic [IDX_W-1:0] count,
  input  logic [7:0]       ctl_rd,
  output logic [7:0]       rd_byte
);
  logic [7:0] lp_lo, lp_hi;

  for (genvar j = 0; j < HALF_W; j++) begin : g_ilv
    assign lp_lo[2*j]   = par_even[j];
    assign lp_lo[2*j+1] = par_odd[j];
    assign lp_hi[2*j]   = par_even[j+HALF_W];
    assign lp_hi[2*j+1] = par_odd[j+HALF_W];
  end

  always_comb begin
    unique case (sel)
      SEL_LPLO: rd_byte = lp_lo;
      SEL_LPHI: rd_byte = lp_hi;
      SEL_COL:  rd_byte = {{(8-COL_W){1'b0}}, col_par};
      SEL_CNT:  rd_byte = count;
      SEL_CTL:  rd_byte = ctl_rd;
      default:  rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/nand_ecc_bridge.sv
`timescale 1ns/1ps
module nand_ecc_bridge
  import nfb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              bad_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we,
  output logic              fl_re,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic [1:0]        fl_ce,
  output logic              fl_wp,
  input  logic              fl_ryby
);
  nfb_state_e state;
  nfb_sel_e   dec_sel, lat_sel;
  logic       lat_write, lat_word, phase;
  logic [7:0] lat_wdata;
  logic [31:0] rdata_q;

  logic [IDX_W-1:0] par_even, par_odd, count;
  logic [COL_W-1:0] col_par;
  logic [7:0]       ctl_rd, mux_byte;
  logic             act, ecc_vld, ecc_clr, ctl_wr;

  always_comb begin
    if      (req_addr == ADDR_W'(OFS_LP_LO)) dec_sel = SEL_LPLO;
    else if (req_addr == ADDR_W'(OFS_LP_HI)) dec_sel = SEL_LPHI;
    else if (req_addr == ADDR_W'(OFS_COL))   dec_sel = SEL_COL;
    else if (req_addr == ADDR_W'(OFS_CNT))   dec_sel = SEL_CNT;
    else if (req_addr == ADDR_W'(OFS_CLR))   dec_sel = SEL_CLR;
    else if (req_addr == ADDR_W'(OFS_IO))    dec_sel = SEL_IO;
    else if (req_addr == ADDR_W'(OFS_CTL))   dec_sel = SEL_CTL;
    else                                     dec_sel = SEL_BAD;
  end

  assign act       = (state == ST_ACT);
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = rdata_q;

  assign fl_we    = act &&  lat_write && (lat_sel == SEL_IO);
  assign fl_re    = act && !lat_write && (lat_sel == SEL_IO);
  assign fl_dout  = lat_wdata;
  assign ctl_wr   = act &&  lat_write && (lat_sel == SEL_CTL);
  assign ecc_clr  = act &&  lat_write && (lat_sel == SEL_CLR);
  // a read of a clear offset is undefined too
  assign bad_addr = act && !lat_write && (lat_sel == SEL_BAD || lat_sel == SEL_CLR);
  assign ecc_vld  = fl_we || fl_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_sel   <= SEL_BAD;
      lat_write <= 1'b0;
      lat_word  <= 1'b0;
      lat_wdata <= '0;
      phase     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          lat_sel   <= dec_sel;
          lat_write <= req_write;
          lat_word  <= req_word;
          lat_wdata <= req_wdata;
          phase     <= 1'b0;
          rdata_q   <= '0;
          state     <= ST_ACT;
        end
        ST_ACT: begin
          if (lat_write) begin
            state <= ST_IDLE;
          end else if (lat_sel == SEL_IO) begin
            if (!phase) rdata_q[7:0]   <= fl_din;
            else        rdata_q[23:16] <= fl_din;
            if (lat_word && !phase) phase <= 1'b1;
            else                    state <= ST_RESP;
          end else begin
            rdata_q <= {24'd0, mux_byte};
            state   <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  nfb_ecc u_ecc (
    .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .byte_vld(ecc_vld),
    .byte_in(fl_re ? fl_din : fl_dout),
    .par_even(par_even), .par_odd(par_odd), .col_par(col_par), .count(count)
  );

  nfb_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(lat_wdata), .ryby(fl_ryby),
    .ctl_rd(ctl_rd), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce(fl_ce), .fl_wp(fl_wp)
  );

  nfb_rdmux u_mux (
    .sel(lat_sel), .par_even(par_even), .par_odd(par_odd), .col_par(col_par),
    .count(count), .ctl_rd(ctl_rd), .rd_byte(mux_byte)
  );

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r11_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r10_bad_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |=> !bad_addr);
  a_r3_single_we: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we);
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  a_r5_word_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_re && !$past(fl_re)) |=> (fl_re == $past(lat_word)));
endmodule

// File: tb/nand_ecc_bridge_tb.sv
`timescale 1ns/1ps
module nand_ecc_bridge_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_word = 0, rsp_ready = 1, fl_ryby = 0;
  logic [7:0] req_addr = 0, req_wdata = 0, fl_din;
  logic req_ready, rsp_valid, bad_addr, fl_we, fl_re, fl_cle, fl_ale, fl_wp;
  logic [31:0] rsp_rdata;
  logic [7:0] fl_dout;
  logic [1:0] fl_ce;

  nand_ecc_bridge u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int we_cnt = 0, re_cnt = 0, bad_cnt = 0;
  logic [7:0] last_we;
  int fptr = 0;
  logic [7:0] hist [0:1023];
  int nh = 0;

  function automatic logic [7:0] pat(input int p);
    return 8'((p * 29 + 7) & 255);
  endfunction
  assign fl_din = pat(fptr);

  always @(posedge clk) begin
    if (fl_re) fptr <= fptr + 1;
    if (fl_we) begin we_cnt <= we_cnt + 1; last_we <= fl_dout; end
    if (fl_re) re_cnt <= re_cnt + 1;
    if (bad_addr) bad_cnt <= bad_cnt + 1;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = 0; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = w; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
  endtask

  // bench-side ECC expectation from the byte history
  task automatic exp_ecc(output logic [7:0] lo, output logic [7:0] hi, output logic [7:0] col);
    logic [7:0] e, o;
    logic [5:0] c;
    e = 0; o = 0; c = 0;
    for (int i = 0; i < nh; i++) begin
      logic p;
      p = ^hist[i];
      for (int k = 0; k < 8; k++)
        if (((i % 256) >> k) & 1) o[k] = o[k] ^ p; else e[k] = e[k] ^ p;
      for (int b = 0; b < 8; b++)
        for (int g = 0; g < 3; g++)
          if ((b >> g) & 1) c[2*g+1] = c[2*g+1] ^ hist[i][b];
          else              c[2*g]   = c[2*g]   ^ hist[i][b];
    end
    lo = {o[3], e[3], o[2], e[2], o[1], e[1], o[0], e[0]};
    hi = {o[7], e[7], o[6], e[6], o[5], e[5], o[4], e[4]};
    col = {2'b00, c};
  endtask

  task automatic chk_ecc(input string rq);
    logic [7:0] lo, hi, col;
    logic [31:0] d;
    exp_ecc(lo, hi, col);
    bus_rd(8'h00, 0, d); chk({rq, " R7 lp low"},  d, {24'd0, lo});
    bus_rd(8'h04, 0, d); chk({rq, " R7 lp high"}, d, {24'd0, hi});
    bus_rd(8'h08, 0, d); chk({rq, " R8 column"},  d, {24'd0, col});
    bus_rd(8'h0C, 0, d); chk({rq, " R6 count"},   d, 32'(nh % 256));
  endtask

  localparam int NV = 8;
  localparam logic [7:0] VEC_IN  [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'h3C, 8'h10, 8'hE7};
  localparam logic [7:0] VEC_CNT [NV] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int we0, re0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 pins", {fl_cle, fl_ale, fl_ce, fl_wp}, 5'd0);
    chk_ecc("R12");
    fl_ryby = 1;
    bus_rd(8'h18, 0, d); chk("R2 ctl reset ryby=1", d, 32'h20);

    // table of data-port writes
    for (int i = 0; i < NV; i++) begin
      we0 = we_cnt;
      bus_wr(8'h14, VEC_IN[i]);
      hist[nh++] = VEC_IN[i];
      chk("R3 one strobe", 32'(we_cnt - we0), 1);
      chk("R3 byte out", last_we, VEC_IN[i]);
      bus_rd(8'h0C, 0, d); chk("R6 count step", d, {24'd0, VEC_CNT[i]});
    end
    chk_ecc("table");

    // R9 clear with non-zero value
    we0 = we_cnt; re0 = re_cnt;
    bus_wr(8'h10, 8'hA5);
    nh = 0;
    chk("R9 no strobe", 32'(we_cnt - we0 + re_cnt - re0), 0);
    chk_ecc("R9 after clear");

    // R4 byte read
    re0 = re_cnt;
    begin
      logic [7:0] b;
      b = pat(fptr);
      bus_rd(8'h14, 0, d);
      hist[nh++] = b;
      chk("R4 byte read", d, {24'd0, b});
      chk("R4 one strobe", 32'(re_cnt - re0), 1);
    end
    // R5 word read
    re0 = re_cnt;
    begin
      logic [7:0] b0v, b1v;
      b0v = pat(fptr); b1v = pat(fptr + 1);
      bus_rd(8'h14, 1, d);
      hist[nh++] = b0v; hist[nh++] = b1v;
      chk("R5 word read", d, {8'd0, b1v, 8'd0, b0v});
      chk("R5 two strobes", 32'(re_cnt - re0), 2);
    end
    bus_wr(8'h14, 8'h6B); hist[nh++] = 8'h6B;
    chk_ecc("R4/R5 mixed");

    // R1/R2 control
    fl_ryby = 0;
    bus_wr(8'h18, 8'hFF);
    chk("R1 pins all", {fl_cle, fl_ale, fl_ce, fl_wp}, 5'b11111);
    bus_rd(8'h18, 0, d); chk("R2 busy low", d, 32'hDF);
    fl_ryby = 1;
    bus_rd(8'h18, 0, d); chk("R2 busy high", d, 32'hFF);
    bus_wr(8'h18, 8'h05);
    chk("R1 pins 05", {fl_cle, fl_ale, fl_ce[1], fl_ce[0], fl_wp}, 5'b01010);
    bus_wr(8'h18, 8'h1A);
    chk("R1 pins 1A", {fl_cle, fl_ale, fl_ce[1], fl_ce[0], fl_wp}, 5'b10101);

    // R10 undefined offsets
    b0 = bad_cnt;
    bus_rd(8'h1C, 0, d); chk("R10 bad read data", d, 0);
    chk("R10 bad pulse", 32'(bad_cnt - b0), 1);
    we0 = we_cnt; re0 = re_cnt;
    bus_wr(8'h1C, 8'hFF);
    bus_wr(8'h00, 8'hFF);
    bus_wr(8'h0C, 8'hFF);
    chk("R10 no strobe", 32'(we_cnt - we0 + re_cnt - re0), 0);
    chk("R10 pins kept", {fl_cle, fl_ale, fl_ce[1], fl_ce[0], fl_wp}, 5'b10101);
    chk("R10 no bad on write", 32'(bad_cnt - b0), 1);
    chk_ecc("R10 ecc kept");

    // R11 back-pressure on response
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = 0; req_addr = 8'h18;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    repeat (5) @(negedge clk);
    chk("R11 rsp held", {31'd0, rsp_valid}, 1);
    chk("R11 data stable", rsp_rdata, d);
    chk("R11 not ready", {31'd0, req_ready}, 0);
    rsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 released", {30'd0, rsp_valid, req_ready}, 2'b01);

    // R6/R7 wrap across 256 bytes
    bus_wr(8'h10, 8'h00); nh = 0;
    for (int i = 0; i < 258; i++) begin
      bus_wr(8'h14, 8'((i * 7 + 3) & 255));
      hist[nh++] = 8'((i * 7 + 3) & 255);
    end
    chk_ecc("R6 wrap");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule